// File: doc/BRIEF.md
# Serial Register-Map Slave with Coherent Time Snapshot

This block is the two-wire (I2C) slave front end of a real-time-clock core. It oversamples SCL and SDA with the system clock and decodes START and STOP. It matches a 7-bit device address and handles a register pointer that auto-increments. Through that pointer it serves a ten-byte map: seven clock bytes (indices 0 to 6), a control byte (7), a charger-setup byte (8) and a status byte (9). The only bus output is an open-drain enable, `sda_oe`. While it is high the pad pulls SDA low.

Reads of the clock bytes come from a user buffer. The buffer copies the running time from the clock core at every START, every STOP, and whenever the pointer steps to 0, so a multi-byte read always returns one consistent instant. Writes to bytes 0 to 7 reach the clock core as a one-cycle strobe with the data byte. The block also keeps the control, charger and status bytes locally. It applies their special rules:
- a keyed enable for the charger;
- a status flag that software can only clear;
- a full bus lockout while the supply is failing.

A pointer loaded beyond 9 reads as 00h, ignores writes and steps back to 0.

Top module: `rtc_i2c_regmap`

## Requirements
- R1: The slave acknowledges the address bytes D0h (write) and D1h (read), i.e. address 1101000b. Any other address byte is not acknowledged, and later bytes are ignored (no acknowledge, no strobe) until the next START.
- R2: In a write transfer, the first byte after the address loads the pointer. Every later byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R3: A read transfer starts at the current pointer, including after an earlier read. Each byte sent advances the pointer. A NACK from the master ends the read with SDA released.
- R4: The pointer steps from 7 to 0 and from 9 to 0. Index 8 is reached only by loading the pointer, and index 9 only from 8 or by a load.
- R5: The clock core's time is copied into the user buffer on START, on STOP, and when the pointer steps to 0. Reads of bytes 0 to 6 return the buffered copy, so time changes during a transfer do not appear.
- R6: A data write to index 0 to 7 raises bit `core_we[index]` for exactly one cycle, with the byte on `core_wdata`. The strobe comes at the start of the slave's acknowledge of that byte, before the master's ninth SCL rise. At most one strobe bit is high at a time.
- R7: Status byte bit 7 is the oscillator-stop flag. Writing 0 to bit 7 clears it, and writing 1 leaves it unchanged. Bits 6 to 0 read as 0.
- R8: In the charger byte, bits 7-4 must hold 1010 to enable charging. Bits 3-2 must be 01 (no diode) or 10 (one diode), and bits 1-0 pick the resistor: 01, 10 or 11. Any other value keeps `chg_en` low. The byte resets to 00h.
- R9: The control byte resets to 80h (output-level bit 7 set, all other bits 0) and reads back what was written.
- R10: While `pwr_fail` is high the slave drives no acknowledge, emits no strobe and changes no register.
- R11: The oscillator-stop flag is 1 after reset and is set by a pulse on `osf_set`. It never rises for any other reason.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| pwr_fail | input | 1 | Supply below the failure threshold; locks out the bus |
| time_i | input | 56 | Running time from the clock core, byte k in bits 8k+7:8k |
| osf_set | input | 1 | Oscillator-stop event from the clock core |
| core_we | output | 8 | One-hot write strobe for indices 0 to 7 |
| core_wdata | output | 8 | Data byte that goes with `core_we` |
| ctrl_o | output | 8 | Control byte |
| chg_en | output | 1 | Charger enabled by a valid key and selection |
| chg_diode | output | 1 | Charger path uses one diode |
| chg_rsel | output | 2 | Charger resistor code (01, 10, 11), 00 when disabled |
| osf_o | output | 1 | Oscillator-stop flag |

## Verification
The in-line assertions check, on every cycle, that the lockout keeps SDA released and strobes quiet. They also check that strobes are one-hot and that the oscillator-stop flag rises only from `osf_set`. A further assertion checks that the pointer always steps from 7 or 9 to 0 unless it was loaded. The following can only be shown by the directed bus transfers:
- address matching and the ignored tail of a foreign transfer;
- pointer loading and continuation across transfers;
- coherent readback against a changing time source;
- keyed charger decoding;
- the write-zero-only flag and acknowledge timing.

// File: rtl/rtcbus_pkg.sv
package rtcbus_pkg;
  localparam int NTIME    = 7;
  localparam int NREG     = 10;
  localparam int PW       = $clog2(NREG);
  localparam int TW       = $clog2(NTIME);
  localparam int CW       = $clog2(NTIME + 1);
  localparam int CTRL_IDX = 7;
  localparam int TRK_IDX  = 8;
  localparam int FLG_IDX  = 9;

  typedef enum logic [2:0] {L_IDLE, L_RX, L_ACK, L_TX, L_TXACK} lstate_t;
  typedef enum logic [1:0] {P_ADDR, P_PTR, P_DATA} phase_t;

  // pointer stepping: control and status both fall back to index 0
  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    if (p == PW'(CTRL_IDX) || p >= PW'(FLG_IDX)) return '0;
    return p + 1'b1;
  endfunction
endpackage

// File: rtl/rtcbus_sync.sv
module rtcbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_c, sda_c;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_c <= '1;
      sda_c <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_c <= {scl_c[STAGES-2:0], scl_i};
      sda_c <= {sda_c[STAGES-2:0], sda_i};
      scl_p <= scl_c[STAGES-1];
      sda_p <= sda_c[STAGES-1];
    end
  end

  assign scl_s     = scl_c[STAGES-1];
  assign sda_lvl   = sda_c[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_lvl;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/rtcbus_link.sv
module rtcbus_link
  import rtcbus_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h68
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_fail,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic [7:0]    rd_data,
  output logic [PW-1:0] ptr,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [PW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          snap
);
  lstate_t       st;
  phase_t        phase;
  logic [2:0]    cnt;
  logic          full, rw, more;
  logic [7:0]    shreg, tx_sh;
  logic [PW-1:0] ptr_nx;
  logic          ptr_load;

  assign ptr_nx   = ptr_next(ptr);
  assign ptr_load = !pwr_fail && !bus_start && !bus_stop && st == L_RX &&
                    scl_fall && full && phase == P_PTR;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= L_IDLE; phase <= P_ADDR; cnt <= '0; full <= 1'b0;
      rw <= 1'b0; more <= 1'b0; shreg <= '0; tx_sh <= '0; ptr <= '0;
      sda_oe <= 1'b0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; snap <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      snap  <= 1'b0;
      if (pwr_fail) begin
        st <= L_IDLE; sda_oe <= 1'b0; full <= 1'b0; more <= 1'b0;
      end else if (bus_start) begin
        st <= L_RX; phase <= P_ADDR; cnt <= '0; full <= 1'b0;
        rw <= 1'b0; more <= 1'b0; sda_oe <= 1'b0; snap <= 1'b1;
      end else if (bus_stop) begin
        st <= L_IDLE; sda_oe <= 1'b0; full <= 1'b0; more <= 1'b0; snap <= 1'b1;
      end else begin
        case (st)
          L_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_lvl};
              cnt   <= cnt + 3'd1;
              if (cnt == 3'd7) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              cnt  <= '0;
              case (phase)
                P_ADDR: begin
                  if (shreg[7:1] == SLV_ADDR) begin
                    rw <= shreg[0]; sda_oe <= 1'b1; st <= L_ACK; phase <= P_PTR;
                  end else begin
                    st <= L_IDLE;
                  end
                end
                P_PTR: begin
                  ptr <= shreg[PW-1:0]; sda_oe <= 1'b1; st <= L_ACK; phase <= P_DATA;
                end
                default: begin
                  wr_en <= 1'b1; wr_addr <= ptr; wr_data <= shreg;
                  ptr <= ptr_nx; snap <= (ptr_nx == '0);
                  sda_oe <= 1'b1; st <= L_ACK;
                end
              endcase
            end
          end
          L_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                tx_sh <= rd_data; sda_oe <= ~rd_data[7];
                ptr <= ptr_nx; snap <= (ptr_nx == '0); cnt <= '0; st <= L_TX;
              end else begin
                sda_oe <= 1'b0; st <= L_RX;
              end
            end
          end
          L_TX: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0; st <= L_TXACK;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
                cnt    <= cnt + 3'd1;
              end
            end
          end
          L_TXACK: begin
            if (scl_rise) begin
              if (sda_lvl) st <= L_IDLE;
              else         more <= 1'b1;
            end else if (scl_fall && more) begin
              more <= 1'b0;
              tx_sh <= rd_data; sda_oe <= ~rd_data[7];
              ptr <= ptr_nx; snap <= (ptr_nx == '0); cnt <= '0; st <= L_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // lockout keeps the data line released
  assert_lock_sda_R10: assert property (@(posedge clk) disable iff (rst)
    $past(pwr_fail) |-> !sda_oe);

  // stepping out of control or status always lands on index 0
  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (($past(ptr) == PW'(CTRL_IDX) || $past(ptr) == PW'(FLG_IDX)) &&
     !$past(ptr_load) && ptr != $past(ptr)) |-> ptr == '0);
endmodule

// File: rtl/rtcbus_regs.sv
module rtcbus_regs
  import rtcbus_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_fail,
  input  logic               wr_en,
  input  logic [PW-1:0]      wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               snap,
  input  logic [NTIME*8-1:0] time_i,
  input  logic               osf_set,
  input  logic [PW-1:0]      rd_ptr,
  output logic [7:0]         rd_data,
  output logic [NTIME:0]     core_we,
  output logic [7:0]         core_wdata,
  output logic [7:0]         ctrl_q,
  output logic [7:0]         trk_q,
  output logic               osf_q
);
  localparam logic [PW-1:0] NT_P   = PW'(NTIME);
  localparam logic [PW-1:0] CTRL_P = PW'(CTRL_IDX);
  localparam logic [PW-1:0] TRK_P  = PW'(TRK_IDX);
  localparam logic [PW-1:0] FLG_P  = PW'(FLG_IDX);

  logic [7:0] tbuf [NTIME];
  logic       wr_ok;

  assign wr_ok = wr_en & ~pwr_fail;

  // user buffer: software writes win over a snapshot in the same cycle
  always_ff @(posedge clk) begin
    if (wr_ok && wr_addr < NT_P) begin
      tbuf[wr_addr[TW-1:0]] <= wr_data;
    end else if (snap) begin
      for (int k = 0; k < NTIME; k++) tbuf[k] <= time_i[k*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_we    <= '0;
      core_wdata <= '0;
      ctrl_q     <= 8'h80;
      trk_q      <= 8'h00;
      osf_q      <= 1'b1;
    end else begin
      core_we <= '0;
      if (wr_ok && wr_addr <= CTRL_P) begin
        core_we[wr_addr[CW-1:0]] <= 1'b1;
        core_wdata <= wr_data;
      end
      if (wr_ok && wr_addr == CTRL_P) ctrl_q <= wr_data;
      if (wr_ok && wr_addr == TRK_P)  trk_q  <= wr_data;
      if (osf_set) osf_q <= 1'b1;
      else if (wr_ok && wr_addr == FLG_P && !wr_data[7]) osf_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_ptr < NT_P)        rd_data = tbuf[rd_ptr[TW-1:0]];
    else if (rd_ptr == CTRL_P) rd_data = ctrl_q;
    else if (rd_ptr == TRK_P)  rd_data = trk_q;
    else if (rd_ptr == FLG_P)  rd_data = {osf_q, 7'b0};
  end

  assert_we_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_we));

  assert_lock_we_R10: assert property (@(posedge clk) disable iff (rst)
    $past(pwr_fail) |-> core_we == '0);

  assert_osf_source_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(osf_q) && osf_q) |-> $past(osf_set));
endmodule

// File: rtl/rtc_i2c_regmap.sv
module rtc_i2c_regmap
  import rtcbus_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'h68,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic               pwr_fail,
  input  logic [NTIME*8-1:0] time_i,
  input  logic               osf_set,
  output logic [NTIME:0]     core_we,
  output logic [7:0]         core_wdata,
  output logic [7:0]         ctrl_o,
  output logic               chg_en,
  output logic               chg_diode,
  output logic [1:0]         chg_rsel,
  output logic               osf_o
);
  logic          sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic [7:0]    rd_data, wr_data, trk_q;
  logic [PW-1:0] ptr, wr_addr;
  logic          wr_en, snap;
  logic          key_ok, ds_ok;

  rtcbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  rtcbus_link #(.SLV_ADDR(SLV_ADDR)) u_link (
    .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
    .bus_stop(bus_stop), .rd_data(rd_data), .ptr(ptr), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .snap(snap)
  );

  rtcbus_regs u_regs (
    .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .snap(snap), .time_i(time_i),
    .osf_set(osf_set), .rd_ptr(ptr), .rd_data(rd_data), .core_we(core_we),
    .core_wdata(core_wdata), .ctrl_q(ctrl_o), .trk_q(trk_q), .osf_q(osf_o)
  );

  // charger decode: key nibble, a legal diode code and a non-zero resistor
  assign key_ok    = (trk_q[7:4] == 4'b1010);
  assign ds_ok     = (trk_q[3:2] == 2'b01) || (trk_q[3:2] == 2'b10);
  assign chg_en    = key_ok && ds_ok && (trk_q[1:0] != 2'b00);
  assign chg_diode = chg_en && (trk_q[3:2] == 2'b10);
  assign chg_rsel  = chg_en ? trk_q[1:0] : 2'b00;
endmodule

// File: tb/rtc_i2c_regmap_test.sv
module rtc_i2c_regmap_test;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        pwr_fail = 1'b0, osf_set = 1'b0;
  logic        sda_oe, chg_en, chg_diode, osf_o;
  logic [1:0]  chg_rsel;
  logic [7:0]  core_we, core_wdata, ctrl_o;
  logic [55:0] time_i;
  logic        sda_line;
  logic [7:0]  t [7];
  logic [7:0]  rb [4];
  int          n_chk = 0, n_bad = 0, we_cnt = 0, last_idx = -1, cyc = 0;
  int          hist [3];
  logic [7:0]  last_data;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  always_comb for (int k = 0; k < 7; k++) time_i[k*8 +: 8] = t[k];

  rtc_i2c_regmap uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .pwr_fail(pwr_fail), .time_i(time_i), .osf_set(osf_set),
    .core_we(core_we), .core_wdata(core_wdata), .ctrl_o(ctrl_o),
    .chg_en(chg_en), .chg_diode(chg_diode), .chg_rsel(chg_rsel), .osf_o(osf_o)
  );

  // clock-core model: applies strobes to the running time
  always @(posedge clk) begin
    if (!rst && core_we != 8'h00) begin
      for (int k = 0; k < 8; k++) if (core_we[k]) begin
        last_idx = k;
        if (k < 7) t[k] <= core_wdata;
      end
      we_cnt    = we_cnt + 1;
      last_data = core_wdata;
      hist[0] = hist[1]; hist[1] = hist[2]; hist[2] = last_idx;
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual=running expected=done");
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic b_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic b_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack, output int we_early);
    logic s;
    int   c0;
    c0 = we_cnt;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    we_early = we_cnt - c0;
    recv_bit(s);
    ack = ~s;
  endtask

  task automatic wb(input logic [7:0] d, output logic ack);
    int e;
    wbyte(d, ack, e);
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin recv_bit(s); d[i] = s; end
    send_bit(~ack);
  endtask

  task automatic wr1(input logic [7:0] p, input logic [7:0] d);
    logic a;
    b_start(); wb(8'hD0, a); wb(p, a); wb(d, a); b_stop();
  endtask

  // load pointer then read n bytes after a repeated start
  task automatic rd_at(input logic [7:0] p, input int n);
    logic a;
    b_start(); wb(8'hD0, a); wb(p, a);
    b_start(); wb(8'hD1, a);
    for (int i = 0; i < n; i++) rbyte(rb[i], i < n - 1);
    b_stop();
  endtask

  task automatic t_reset();
    chk("R9 ctrl reset", ctrl_o, 8'h80);
    chk("R11 osf reset", osf_o, 1'b1);
    chk("R8 charger off at reset", chg_en, 1'b0);
    chk("R10 sda released at reset", sda_oe, 1'b0);
    chk("R6 no strobe at reset", core_we, 8'h00);
  endtask

  task automatic t_write_read();
    logic a; int e; int c0;
    c0 = we_cnt;
    b_start();
    wb(8'hD0, a);            chk("R1 write address ack", a, 1'b1);
    wb(8'h00, a);            chk("R2 pointer ack", a, 1'b1);
    wbyte(8'h12, a, e);      chk("R2 data ack", a, 1'b1);
    chk("R6 strobe before ninth clock", e, 1);
    wbyte(8'h34, a, e);
    wbyte(8'h56, a, e);      chk("R2 data ack last", a, 1'b1);
    b_stop();
    chk("R6 strobe count", we_cnt - c0, 3);
    chk("R6 last strobe index", last_idx, 2);
    chk("R6 last strobe data", last_data, 8'h56);
    chk("R2 core byte1", t[1], 8'h34);
    rd_at(8'h00, 3);
    chk("R3 read byte0", rb[0], 8'h12);
    chk("R3 read byte1", rb[1], 8'h34);
    chk("R3 read byte2", rb[2], 8'h56);
    b_start(); wb(8'hD1, a); rbyte(rb[0], 1'b0);
    chk("R3 read continues at pointer 3", rb[0], 8'h05);
    qw();
    chk("R3 sda released after nack", sda_oe, 1'b0);
    b_stop();
  endtask

  task automatic t_wrap7();
    logic a;
    b_start(); wb(8'hD0, a); wb(8'h06, a);
    wb(8'h24, a); wb(8'h45, a); wb(8'h30, a); b_stop();
    chk("R4 strobe order 06", hist[0], 6);
    chk("R4 strobe order 07", hist[1], 7);
    chk("R4 wrap to 00", hist[2], 0);
    chk("R9 ctrl written", ctrl_o, 8'h45);
    chk("R4 byte0 after wrap", t[0], 8'h30);
    rd_at(8'h07, 2);
    chk("R9 ctrl readback", rb[0], 8'h45);
    chk("R4 read wrap 07 to 00", rb[1], 8'h30);
  endtask

  task automatic t_wrap9();
    logic a; int c0;
    c0 = we_cnt;
    b_start(); wb(8'hD0, a); wb(8'h08, a);
    wb(8'hA6, a); wb(8'h00, a); wb(8'h11, a); b_stop();
    chk("R4 only wrapped byte strobed", we_cnt - c0, 1);
    chk("R4 wrap 09 to 00", t[0], 8'h11);
    chk("R8 A6 enables", {chg_en, chg_diode, chg_rsel}, 4'b1010);
    chk("R7 flag cleared by 0", osf_o, 1'b0);
    rd_at(8'h08, 3);
    chk("R8 charger readback", rb[0], 8'hA6);
    chk("R7 flag reads 00", rb[1], 8'h00);
    chk("R4 read wrap 09 to 00", rb[2], 8'h11);
  endtask

  task automatic t_osf();
    @(negedge clk); osf_set = 1'b1; @(negedge clk); osf_set = 1'b0; @(negedge clk);
    chk("R11 osf set by event", osf_o, 1'b1);
    wr1(8'h09, 8'hFF);
    chk("R7 writing 1 leaves flag", osf_o, 1'b1);
    rd_at(8'h09, 1);
    chk("R7 low bits read 0", rb[0], 8'h80);
    wr1(8'h09, 8'h7F);
    chk("R7 writing 0 clears", osf_o, 1'b0);
    rd_at(8'h09, 1);
    chk("R7 cleared readback", rb[0], 8'h00);
  endtask

  task automatic t_key();
    wr1(8'h08, 8'hB6); chk("R8 wrong key", chg_en, 1'b0);
    wr1(8'h08, 8'hA0); chk("R8 diode code 00", chg_en, 1'b0);
    wr1(8'h08, 8'hAB); chk("R8 diode + 4k", {chg_en, chg_diode, chg_rsel}, 4'b1111);
    wr1(8'h08, 8'hA4); chk("R8 resistor 00", chg_en, 1'b0);
  endtask

  task automatic t_mismatch();
    logic a; int c0;
    c0 = we_cnt;
    b_start(); wb(8'hA0, a); chk("R1 foreign address nack", a, 1'b0);
    wb(8'h00, a);             chk("R1 tail ignored", a, 1'b0);
    wb(8'h77, a);             chk("R1 tail data ignored", a, 1'b0);
    b_stop();
    chk("R1 no strobe from foreign", we_cnt - c0, 0);
    b_start(); wb(8'hD3, a); chk("R1 near-miss read nack", a, 1'b0); b_stop();
    b_start(); wb(8'hD1, a); chk("R1 read address ack", a, 1'b1);
    rbyte(rb[0], 1'b0); b_stop();
  endtask

  task automatic t_snap();
    logic a;
    t[0] = 8'h40; t[1] = 8'h41;
    b_start(); wb(8'hD0, a); wb(8'h00, a);
    b_start(); wb(8'hD1, a);
    rbyte(rb[0], 1'b1);
    t[1] = 8'h99;
    rbyte(rb[1], 1'b0); b_stop();
    chk("R5 snapshot byte0", rb[0], 8'h40);
    chk("R5 mid-read change hidden", rb[1], 8'h41);
    rd_at(8'h01, 1);
    chk("R5 new start refreshes", rb[0], 8'h99);
    b_start(); wb(8'hD0, a); wb(8'h06, a);
    b_start(); wb(8'hD1, a);
    t[0] = 8'h5A;
    rbyte(rb[0], 1'b1); rbyte(rb[1], 1'b1); rbyte(rb[2], 1'b0); b_stop();
    chk("R5 wrap refreshes buffer", rb[2], 8'h5A);
  endtask

  task automatic t_lock();
    logic a; int c0; logic [7:0] tr;
    tr = 8'hA6;
    wr1(8'h08, tr);
    c0 = we_cnt;
    pwr_fail = 1'b1;
    b_start(); wb(8'hD0, a); chk("R10 no ack in lockout", a, 1'b0);
    wb(8'h08, a); wb(8'h00, a); wb(8'h22, a);
    chk("R10 data not acked", a, 1'b0);
    b_stop();
    chk("R10 no strobes", we_cnt - c0, 0);
    pwr_fail = 1'b0; qw();
    chk("R10 charger unchanged", chg_en, 1'b1);
    rd_at(8'h08, 1);
    chk("R10 register unchanged", rb[0], tr);
  endtask

  initial begin
    for (int k = 0; k < 7; k++) t[k] = 8'h00;
    t[3] = 8'h05;
    hist[0] = -1; hist[1] = -1; hist[2] = -1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_wrap7();
    t_wrap9();
    t_osf();
    t_key();
    t_mismatch();
    t_snap();
    t_lock();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule